// File: doc/BRIEF.md
# Guarded Clock Division Control Register

This block holds the setting of a power-of-two divider for the system clock. Software reaches it through one 8-bit register. The block turns the stored setting into a clock-enable pulse that fires once every N master clock cycles, with N between 1 and 256. Downstream synchronous logic qualifies its registers with that pulse, so every consumer slows by the same factor.

An accidental store must not be able to change the clock rate. For that reason the division field moves only after a two-step unlock. First, a write must set the top bit with every other bit zero. Then, while that unlock bit is still set, a second write with the top bit clear carries the new code. The unlock bit clears by itself after four cycles, or as soon as a code write lands. Writing the unlock pattern again while the window is open changes nothing. At reset a fuse input picks the start-up division: divide by 1 normally, or divide by 8 when the fuse is asserted.

A new code does not cut the running period short. It takes over only when the current period reaches its terminal count.

Top module: `prot_clk_divider`

## Requirements
- R1: During and after synchronous reset (rst_n low), the register reads 8'h00 when fuse_div8 is low and 8'h03 when fuse_div8 is high.
- R2: The unlock bit (bit 7) becomes 1 only after a write of exactly 8'h80. A write with bit 7 set and any of bits 6:0 nonzero changes neither the unlock bit nor the code field.
- R3: Once set, the unlock bit reads 1 for four cycles and 0 from the fifth cycle on. A code write is accepted on any of the four clock edges that follow the unlock write.
- R4: Writing 8'h80 again while the window is open neither clears the unlock bit nor restarts the four-cycle timeout.
- R5: A write with bit 7 clear updates the code field (bits 3:0) only while the unlock bit is 1. The same write clears the unlock bit. Outside the window such a write has no effect.
- R6: Codes 4'h9 to 4'hF are reserved. A write of a reserved code inside the window leaves the field unchanged but still closes the window.
- R7: Bits 6:4 always read 0. Values written to them are ignored, and the code field is still taken from bits 3:0.
- R8: Code c in 0 to 8 makes clk_en_o pulse high for one cycle every 2^c master cycles.
- R9: With code 0, clk_en_o is high on every cycle.
- R10: A new code takes effect only after the current period's terminal count. The period in progress keeps its old length and the next period uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fuse_div8 | input | 1 | Selects divide-by-8 as the reset setting |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data: {unlock, 3'b000, code} |
| clk_en_o | output | 1 | Divided clock-enable pulse |

## Verification
The assertions assume the following about the inputs:
- wr_en is a clean single-cycle strobe, synchronous to clk, with wr_data valid in the same cycle.
- fuse_div8 is held steady while rst_n is low.
- rst_n stays low for at least several cycles, so the window-age checker starts from a known zero.

The bench changes every input on the falling clock edge. It holds the fuse value through a reset of five cycles. It issues writes as isolated one-cycle strobes, back to back where the window timing calls for it.

// File: rtl/prot_div_pkg.sv
package prot_div_pkg;

    localparam int REG_W      = 8;
    localparam int CODE_W     = 4;
    localparam int MAX_CODE   = 8;
    localparam int WIN_CYCLES = 4;
    localparam int FUSE_CODE  = 3;

    function automatic int unsigned bits_for(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pdiv_unlock.sv
module pdiv_unlock
    import prot_div_pkg::*;
#(
    parameter int DATA_W  = REG_W,
    parameter int WIN_CYC = WIN_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              unlock_o,
    output logic              code_wr_o
);
    localparam int LEFT_W = bits_for(WIN_CYC);
    localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(WIN_CYC - 1);
    localparam logic [DATA_W-1:0] UNLOCK_PAT = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic              open;
        logic [LEFT_W-1:0] left;
    } win_t;

    win_t win_d, win_q;
    logic unlock_wr;
    logic code_wr;

    always_comb begin
        unlock_wr = wr_en && (wr_data == UNLOCK_PAT);
        code_wr   = wr_en && !wr_data[DATA_W-1] && win_q.open;
        win_d     = win_q;
        if (win_q.open) begin
            if (code_wr) begin
                win_d.open = 1'b0;
                win_d.left = '0;
            end else if (win_q.left == '0) begin
                win_d.open = 1'b0;
            end else begin
                win_d.left = win_q.left - 1'b1;
            end
        end else if (unlock_wr) begin
            win_d.open = 1'b1;
            win_d.left = LEFT_INIT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign unlock_o  = win_q.open;
    assign code_wr_o = code_wr;

    // window-age checker: consecutive cycles the unlock bit has been high
    logic [7:0] chk_age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_age_q <= '0;
        end else if (win_q.open) begin
            chk_age_q <= (chk_age_q == 8'hFF) ? chk_age_q : chk_age_q + 8'd1;
        end else begin
            chk_age_q <= '0;
        end
    end

    p_open_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_q.open) |-> $past(unlock_wr));

    p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.open |-> (chk_age_q < 8'(WIN_CYC)));

    p_code_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        code_wr |=> !win_q.open);

endmodule

// File: rtl/pdiv_select.sv
module pdiv_select
    import prot_div_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int SEL_W  = CODE_W,
    parameter int MAXC   = MAX_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rst_code_i,
    input  logic              code_wr_i,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEL_W-1:0]  code_o
);
    typedef struct packed {
        logic [SEL_W-1:0] code;
    } sel_t;

    sel_t sel_d, sel_q;
    logic [SEL_W-1:0] new_code;
    logic             legal;

    always_comb begin
        new_code = wr_data[SEL_W-1:0];
        legal    = (32'(new_code) <= MAXC);
        sel_d    = sel_q;
        if (code_wr_i && legal) begin
            sel_d.code = new_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q.code <= rst_code_i;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign code_o = sel_q.code;

    p_code_needs_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_q.code) |-> $past(code_wr_i));

    p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel_q.code) <= MAXC);

endmodule

// File: rtl/pdiv_divider.sv
module pdiv_divider
    import prot_div_pkg::*;
#(
    parameter int SEL_W = CODE_W,
    parameter int MAXC  = MAX_CODE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rst_code_i,
    input  logic [SEL_W-1:0] code_i,
    output logic             tick_o
);
    localparam int CNT_W = (MAXC > 0) ? MAXC : 1;

    typedef struct packed {
        logic [SEL_W-1:0] active;
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;
    logic             term;

    always_comb begin
        span  = (CNT_W+1)'(1) << div_q.active;
        limit = CNT_W'(span - 1'b1);
        term  = (div_q.cnt == limit);
        div_d = div_q;
        if (term) begin
            div_d.cnt    = '0;
            div_d.active = code_i;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q.active <= rst_code_i;
            div_q.cnt    <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o = term;

    p_switch_at_tc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q.active) |-> $past(tick_o));

    p_div1_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.active == '0) && $past(div_q.active == '0) |-> tick_o && $past(tick_o));

endmodule

// File: rtl/prot_clk_divider.sv
module prot_clk_divider
    import prot_div_pkg::*;
#(
    parameter int DATA_W  = REG_W,
    parameter int SEL_W   = CODE_W,
    parameter int MAXC    = MAX_CODE,
    parameter int WIN_CYC = WIN_CYCLES,
    parameter int FUSE_C  = FUSE_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse_div8,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_en_o
);
    localparam int PAD_W = DATA_W - 1 - SEL_W;

    logic             unlock;
    logic             code_wr;
    logic [SEL_W-1:0] code;
    logic [SEL_W-1:0] rst_code;

    assign rst_code = fuse_div8 ? SEL_W'(FUSE_C) : '0;

    pdiv_unlock #(.DATA_W(DATA_W), .WIN_CYC(WIN_CYC)) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .unlock_o  (unlock),
        .code_wr_o (code_wr)
    );

    pdiv_select #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MAXC(MAXC)) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_code_i (rst_code),
        .code_wr_i  (code_wr),
        .wr_data    (wr_data),
        .code_o     (code)
    );

    pdiv_divider #(.SEL_W(SEL_W), .MAXC(MAXC)) u_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_code_i (rst_code),
        .code_i     (code),
        .tick_o     (clk_en_o)
    );

    assign rd_data = {unlock, {PAD_W{1'b0}}, code};

    p_reset_value_r1: assert property (@(posedge clk)
        $past(!rst_n) && !$past(wr_en) |-> rd_data == {{(DATA_W-SEL_W){1'b0}}, $past(rst_code)});

endmodule

// File: tb/prot_clk_divider_bench.sv
module prot_clk_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fuse_div8 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       clk_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    prot_clk_divider u_prot_clk_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .fuse_div8 (fuse_div8),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .clk_en_o  (clk_en_o)
    );

    // row = {wr, data, expected read-back, requirement number}
    localparam int NV = 24;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 8'h80, 8'h80, 4'd2},  // R2 unlock opens
        {1'b1, 8'h03, 8'h03, 4'd5},  // R5 code accepted, window closes
        {1'b1, 8'h05, 8'h03, 4'd5},  // R5 outside window ignored
        {1'b1, 8'h80, 8'h83, 4'd2},
        {1'b1, 8'h80, 8'h83, 4'd4},  // R4 rewrite no effect
        {1'b0, 8'h00, 8'h83, 4'd4},
        {1'b0, 8'h00, 8'h83, 4'd3},
        {1'b1, 8'h01, 8'h01, 4'd3},  // R3 fourth edge still accepted
        {1'b1, 8'h80, 8'h81, 4'd2},
        {1'b0, 8'h00, 8'h81, 4'd3},
        {1'b0, 8'h00, 8'h81, 4'd3},
        {1'b0, 8'h00, 8'h81, 4'd3},
        {1'b0, 8'h00, 8'h01, 4'd3},  // R3 timeout
        {1'b1, 8'h02, 8'h01, 4'd5},  // R5 too late
        {1'b1, 8'h80, 8'h81, 4'd2},
        {1'b1, 8'h0A, 8'h01, 4'd6},  // R6 reserved code
        {1'b1, 8'h80, 8'h81, 4'd2},
        {1'b1, 8'h81, 8'h81, 4'd2},  // R2 bit7 with nonzero ignored
        {1'b1, 8'h74, 8'h04, 4'd7},  // R7 bits 6:4 dropped
        {1'b1, 8'h80, 8'h84, 4'd2},
        {1'b1, 8'h08, 8'h08, 4'd5},
        {1'b1, 8'h80, 8'h88, 4'd2},
        {1'b1, 8'h00, 8'h00, 4'd5},
        {1'b1, 8'h90, 8'h00, 4'd2}   // R2 bad unlock pattern
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic fuse);
        rst_n     = 1'b0;
        fuse_div8 = fuse;
        wr_en     = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_code(input logic [7:0] c);
        wr_en = 1'b1; wr_data = 8'h80;
        @(negedge clk);
        wr_data = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!clk_en_o);
    endtask

    task automatic gap_from_pulse(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!clk_en_o);
    endtask

    initial begin
        int gap;
        @(negedge clk);
        do_reset(1'b0);
        @(negedge clk);
        check(rd_data == 8'h00, "R1 reset fuse low", rd_data, 8'h00);
        for (int k = 0; k < 6; k++) begin
            check(clk_en_o == 1'b1, "R9 divide by one steady", clk_en_o, 1);
            @(negedge clk);
        end

        for (int i = 0; i < NV; i++) begin
            wr_en   = VEC[i][20];
            wr_data = VEC[i][19:12];
            @(negedge clk);
            n_checks++;
            if (rd_data !== VEC[i][11:4]) begin
                n_fail++;
                $display("FAIL R%0d row %0d: actual %0h expected %0h",
                         VEC[i][3:0], i, rd_data, VEC[i][11:4]);
            end
        end
        wr_en = 1'b0;

        for (int c = 0; c <= 8; c += 2) begin
            set_code(8'(c));
            wait_pulse();
            gap_from_pulse(gap);
            check(gap == (1 << c), "R8 period", gap, 1 << c);
        end
        set_code(8'h05);
        wait_pulse();
        gap_from_pulse(gap);
        check(gap == 32, "R8 period code 5", gap, 32);

        // R10: change from 256 to 2 mid-period
        set_code(8'h08);
        wait_pulse();
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (gap == 10) begin wr_en = 1'b1; wr_data = 8'h80; end
            if (gap == 11) wr_data = 8'h01;
            if (gap == 12) wr_en = 1'b0;
        end while (!clk_en_o);
        check(gap == 256, "R10 running period kept", gap, 256);
        gap_from_pulse(gap);
        check(gap == 2, "R10 new period applied", gap, 2);

        do_reset(1'b1);
        @(negedge clk);
        check(rd_data == 8'h03, "R1 reset fuse high", rd_data, 8'h03);
        wait_pulse();
        gap_from_pulse(gap);
        check(gap == 8, "R1 fuse period", gap, 8);

        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule